// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD timing controller's supply rails and interface controls up and down in a fixed, safe order. It does so by issuing single-cycle 8-bit writes to the controller's addressed control registers. A power-on request carries a resolution mode, either full (VGA) or quarter (QVGA). On the first power-on the block runs the full cold sequence. This covers the rail enables, the interface-control changes, a programmed common-voltage level and millisecond settling waits. Once the panel is initialized, a later power-on only rewrites the phase and resolution registers.

The common-voltage level goes out through an external DAC serializer. The block pulses a start strobe with the value and waits for that unit's done pulse before it continues. A power-off request runs the shutdown order, which ends by clearing the initialized flag. All waits are counted in clock cycles from a cycles-per-millisecond parameter.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `ready` and `busy` are 0, and neither `wr_valid` nor `dac_start` is asserted until a request arrives.
- R2: A power-on while `ready` is 0 emits this exact write order as (address, data):
  - (6,0x1F), (3,0x00), (4,0x00), (4,0x04)
  - wait 3 ms
  - (3,0x04), (6,0x09)
  - DAC command
  - (3,0x14), (4,0x06)
  - wait 2 ms
  - (6,0x01), (3,0x1C), (4,0x07), (6,0x00)
  - phase write to address 1
  - (7,0x00)
  - wait 1 ms
  - resolution write to address 0
- R3: Each write that follows a wait of M ms arrives exactly M*CYC_PER_MS+2 cycles after the write before it. The first power-down write comes at least 34*CYC_PER_MS cycles after the previous write.
- R4: A DAC command is a one-cycle `dac_start` pulse with `dac_value`. No further write happens until `dac_done` is seen. During power-on the value is `vcom_val` when `vcom_ok` is 1, and 125 otherwise.
- R5: The phase write carries {3'b000, adj[3:0], 1'b1}. In QVGA adj is 9 (data 0x13). In VGA adj is `phase_adj` when `phase_ok` is 1 (so adj 5 gives 0x0B), and the data is 0x01 when `phase_ok` is 0.
- R6: Every power-on ends with a resolution write of 0x01 for QVGA (`mode_vga`=0) or 0x00 for VGA. `ready` becomes 1 right after it.
- R7: A power-on while `ready` is 1 emits only the phase write and then the resolution write.
- R8: A power-off emits this order, then clears `ready`:
  - wait 34 ms
  - (4,0x06), (6,0x08), (3,0x14)
  - DAC command with value 0
  - (4,0x04), (3,0x04), (6,0x1E), (3,0x00), (4,0x00)
- R9: A power-off request that arrives during a sequence is held. The power-off sequence starts as soon as that sequence ends.
- R10: A power-on request that arrives while `busy` is 1 is ignored and produces no writes.
- R11: `wr_valid` and `dac_start` are asserted only while `busy` is 1. `busy` stays 1 from the cycle after a request is accepted until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_req | input | 1 | Power-on request pulse |
| mode_vga | input | 1 | Resolution for the power-on: 1 = VGA, 0 = QVGA |
| off_req | input | 1 | Power-off request pulse |
| vcom_val | input | 8 | Stored common-voltage level |
| vcom_ok | input | 1 | Stored common-voltage level is valid |
| phase_adj | input | 4 | Stored phase adjustment |
| phase_ok | input | 1 | Stored phase adjustment is valid |
| dac_done | input | 1 | DAC serializer finished pulse |
| wr_valid | output | 1 | Register write strobe |
| wr_addr | output | 3 | Register address |
| wr_data | output | 8 | Register data |
| dac_start | output | 1 | DAC serializer start pulse |
| dac_value | output | 8 | Value for the DAC serializer |
| busy | output | 1 | A sequence is running |
| ready | output | 1 | Panel is initialized |

## Verification
The embedded properties watch every cycle for four things:
- writes or DAC strobes outside a sequence;
- a DAC strobe coinciding with a write;
- a phase write without its fixed low bit;
- the initialized flag changing other than right after the resolution write (set) or the final supply-off write (clear).

Only the bench scenarios can show the full register order, the exact settling-gap lengths and the default-value substitutions. The same holds for the warm path, an off request held until a cold power-on completes, and a power-on request being ignored mid-sequence.

// File: rtl/lps_pkg.sv
package lps_pkg;

   localparam logic [2:0] A_RES   = 3'd0;
   localparam logic [2:0] A_PHASE = 3'd1;
   localparam logic [2:0] A_PWR0  = 3'd3;
   localparam logic [2:0] A_PWR1  = 3'd4;
   localparam logic [2:0] A_IFC   = 3'd6;
   localparam logic [2:0] A_POL   = 3'd7;

   localparam int MS_W      = 6;
   localparam int IDX_W     = 5;
   localparam int COLD_IDX  = 0;
   localparam int WARM_IDX  = 19;
   localparam int DOWN_IDX  = 21;

   typedef enum logic [2:0] {K_WR, K_WAIT, K_DAC, K_PHASE, K_RES} kind_e;
   typedef enum logic [1:0] {F_NONE, F_UP, F_DOWN} fin_e;

   typedef struct packed {
      kind_e            kind;
      logic [2:0]       addr;
      logic [7:0]       data;   // for K_DAC: bit0 = use common-voltage setting
      logic [MS_W-1:0]  ms;
      fin_e             fin;
   } step_t;

   function automatic step_t mk(kind_e k, logic [2:0] a, logic [7:0] d,
                                logic [MS_W-1:0] m, fin_e f);
      step_t s;
      s.kind = k; s.addr = a; s.data = d; s.ms = m; s.fin = f;
      return s;
   endfunction

   function automatic step_t step_at(logic [IDX_W-1:0] i);
      case (i)
         // cold power-up
         5'd0:  return mk(K_WR,    A_IFC,   8'h1F, '0, F_NONE);
         5'd1:  return mk(K_WR,    A_PWR0,  8'h00, '0, F_NONE);
         5'd2:  return mk(K_WR,    A_PWR1,  8'h00, '0, F_NONE);
         5'd3:  return mk(K_WR,    A_PWR1,  8'h04, '0, F_NONE);
         5'd4:  return mk(K_WAIT,  A_RES,   8'h00, 6'd3, F_NONE);
         5'd5:  return mk(K_WR,    A_PWR0,  8'h04, '0, F_NONE);
         5'd6:  return mk(K_WR,    A_IFC,   8'h09, '0, F_NONE);
         5'd7:  return mk(K_DAC,   A_RES,   8'h01, '0, F_NONE);
         5'd8:  return mk(K_WR,    A_PWR0,  8'h14, '0, F_NONE);
         5'd9:  return mk(K_WR,    A_PWR1,  8'h06, '0, F_NONE);
         5'd10: return mk(K_WAIT,  A_RES,   8'h00, 6'd2, F_NONE);
         5'd11: return mk(K_WR,    A_IFC,   8'h01, '0, F_NONE);
         5'd12: return mk(K_WR,    A_PWR0,  8'h1C, '0, F_NONE);
         5'd13: return mk(K_WR,    A_PWR1,  8'h07, '0, F_NONE);
         5'd14: return mk(K_WR,    A_IFC,   8'h00, '0, F_NONE);
         5'd15: return mk(K_PHASE, A_PHASE, 8'h00, '0, F_NONE);
         5'd16: return mk(K_WR,    A_POL,   8'h00, '0, F_NONE);
         5'd17: return mk(K_WAIT,  A_RES,   8'h00, 6'd1, F_NONE);
         5'd18: return mk(K_RES,   A_RES,   8'h00, '0, F_UP);
         // warm power-up
         5'd19: return mk(K_PHASE, A_PHASE, 8'h00, '0, F_NONE);
         5'd20: return mk(K_RES,   A_RES,   8'h00, '0, F_UP);
         // power-down
         5'd21: return mk(K_WAIT,  A_RES,   8'h00, 6'd34, F_NONE);
         5'd22: return mk(K_WR,    A_PWR1,  8'h06, '0, F_NONE);
         5'd23: return mk(K_WR,    A_IFC,   8'h08, '0, F_NONE);
         5'd24: return mk(K_WR,    A_PWR0,  8'h14, '0, F_NONE);
         5'd25: return mk(K_DAC,   A_RES,   8'h00, '0, F_NONE);
         5'd26: return mk(K_WR,    A_PWR1,  8'h04, '0, F_NONE);
         5'd27: return mk(K_WR,    A_PWR0,  8'h04, '0, F_NONE);
         5'd28: return mk(K_WR,    A_IFC,   8'h1E, '0, F_NONE);
         5'd29: return mk(K_WR,    A_PWR0,  8'h00, '0, F_NONE);
         5'd30: return mk(K_WR,    A_PWR1,  8'h00, '0, F_DOWN);
         default: return mk(K_WR, A_PWR1,  8'h00, '0, F_DOWN);
      endcase
   endfunction

endpackage

// File: rtl/lps_ms_timer.sv
module lps_ms_timer #(
   parameter int CYC_PER_MS = 50000,
   parameter int MS_W       = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [MS_W-1:0] ms,
   output logic            active,
   output logic            expire
);
   localparam int MAX_CYC = CYC_PER_MS * ((1 << MS_W) - 1);
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (start) begin
         cnt    <= CNT_W'(ms) * CNT_W'(CYC_PER_MS) - CNT_W'(1);
         active <= 1'b1;
      end else if (active) begin
         if (cnt == '0) active <= 1'b0;
         else           cnt    <= cnt - CNT_W'(1);
      end
   end

   assign expire = active && (cnt == '0);

   assert_ms_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (ms != '0));
   assert_wait_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !active);
endmodule

// File: rtl/lps_step_dec.sv
module lps_step_dec import lps_pkg::*; #(
   parameter int DEF_VCOM = 125,
   parameter int QVGA_ADJ = 9
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             mode_vga,
   input  logic [7:0]       vcom_val,
   input  logic             vcom_ok,
   input  logic [3:0]       phase_adj,
   input  logic             phase_ok,
   output step_t            step
);
   localparam logic [7:0] VCOM_DEF8 = 8'(DEF_VCOM);
   localparam logic [3:0] QVGA_A4   = 4'(QVGA_ADJ);

   step_t      raw;
   logic [7:0] phase_byte;

   always_comb begin
      raw = step_at(idx);
      if (!mode_vga)     phase_byte = {3'b000, QVGA_A4, 1'b1};
      else if (phase_ok) phase_byte = {3'b000, phase_adj, 1'b1};
      else               phase_byte = 8'h01;
      step = raw;
      unique case (raw.kind)
         K_PHASE: step.data = phase_byte;
         K_RES:   step.data = mode_vga ? 8'h00 : 8'h01;
         K_DAC:   step.data = raw.data[0] ? (vcom_ok ? vcom_val : VCOM_DEF8) : 8'h00;
         default: step.data = raw.data;
      endcase
   end
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq import lps_pkg::*; #(
   parameter int CYC_PER_MS = 50000,
   parameter int DEF_VCOM   = 125,
   parameter int QVGA_ADJ   = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       on_req,
   input  logic       mode_vga,
   input  logic       off_req,
   input  logic [7:0] vcom_val,
   input  logic       vcom_ok,
   input  logic [3:0] phase_adj,
   input  logic       phase_ok,
   input  logic       dac_done,
   output logic       wr_valid,
   output logic [2:0] wr_addr,
   output logic [7:0] wr_data,
   output logic       dac_start,
   output logic [7:0] dac_value,
   output logic       busy,
   output logic       ready
);
   generate
      if (CYC_PER_MS < 1) begin : g_bad_cpm
         $error("CYC_PER_MS must be at least 1");
      end
      if (DEF_VCOM < 0 || DEF_VCOM > 255) begin : g_bad_vcom
         $error("DEF_VCOM must fit in 8 bits");
      end
      if (QVGA_ADJ < 0 || QVGA_ADJ > 15) begin : g_bad_adj
         $error("QVGA_ADJ must fit in 4 bits");
      end
   endgenerate

   logic             running, off_pend, mode_q, dac_issued;
   logic [IDX_W-1:0] idx;
   step_t            step;
   logic             tmr_active, tmr_expire, tmr_start;
   logic             is_wr, adv;

   lps_step_dec #(.DEF_VCOM(DEF_VCOM), .QVGA_ADJ(QVGA_ADJ)) u_dec (
      .idx(idx), .mode_vga(mode_q), .vcom_val(vcom_val), .vcom_ok(vcom_ok),
      .phase_adj(phase_adj), .phase_ok(phase_ok), .step(step));

   lps_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .ms(step.ms),
      .active(tmr_active), .expire(tmr_expire));

   always_comb begin
      is_wr     = running && (step.kind inside {K_WR, K_PHASE, K_RES});
      tmr_start = running && (step.kind == K_WAIT) && !tmr_active;
      dac_start = running && (step.kind == K_DAC) && !dac_issued;
      adv       = is_wr
                | (running && (step.kind == K_WAIT) && tmr_expire)
                | (running && (step.kind == K_DAC) && dac_issued && dac_done);
      wr_valid  = is_wr;
      wr_addr   = is_wr ? step.addr : 3'd0;
      wr_data   = is_wr ? step.data : 8'h00;
      dac_value = (running && step.kind == K_DAC) ? step.data : 8'h00;
      busy      = running;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running    <= 1'b0;
         off_pend   <= 1'b0;
         mode_q     <= 1'b0;
         dac_issued <= 1'b0;
         ready      <= 1'b0;
         idx        <= '0;
      end else if (!running) begin
         if (off_pend) begin
            running  <= 1'b1;
            off_pend <= 1'b0;
            idx      <= IDX_W'(DOWN_IDX);
         end else if (on_req) begin
            running <= 1'b1;
            mode_q  <= mode_vga;
            idx     <= ready ? IDX_W'(WARM_IDX) : IDX_W'(COLD_IDX);
         end else if (off_req) begin
            running <= 1'b1;
            idx     <= IDX_W'(DOWN_IDX);
         end
      end else begin
         if (off_req)   off_pend   <= 1'b1;
         if (dac_start) dac_issued <= 1'b1;
         if (adv) begin
            dac_issued <= 1'b0;
            if (step.fin != F_NONE) begin
               ready <= (step.fin == F_UP);
               if (off_pend || off_req) begin
                  off_pend <= 1'b0;
                  idx      <= IDX_W'(DOWN_IDX);
               end else begin
                  running  <= 1'b0;
               end
            end else begin
               idx <= idx + IDX_W'(1);
            end
         end
      end
   end

   assert_wr_in_seq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> busy);
   assert_dac_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dac_start |-> (busy && !wr_valid));
   assert_phase_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr == A_PHASE) |-> wr_data[0]);
   assert_ready_after_res_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(wr_valid && wr_addr == A_RES));
   assert_ready_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(wr_valid && wr_addr == A_PWR1 && wr_data == 8'h00));
endmodule

// File: tb/lcd_pwr_seq_tb.sv
`timescale 1ns/1ps
module lcd_pwr_seq_tb;
   localparam int N = 10;   // cycles per ms in the bench

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       on_req = 1'b0, mode_vga = 1'b0, off_req = 1'b0;
   logic [7:0] vcom_val = 8'h00;
   logic       vcom_ok = 1'b0;
   logic [3:0] phase_adj = 4'h0;
   logic       phase_ok = 1'b0;
   logic       dac_done;
   logic       wr_valid, dac_start, busy, ready;
   logic [2:0] wr_addr;
   logic [7:0] wr_data, dac_value;

   always #10 clk = ~clk;

   lcd_pwr_seq #(.CYC_PER_MS(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .on_req(on_req), .mode_vga(mode_vga),
      .off_req(off_req), .vcom_val(vcom_val), .vcom_ok(vcom_ok),
      .phase_adj(phase_adj), .phase_ok(phase_ok), .dac_done(dac_done),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .dac_start(dac_start), .dac_value(dac_value), .busy(busy), .ready(ready));

   // DAC serializer model: done pulse three cycles after start
   int dcnt = 0;
   always @(posedge clk) begin
      if (dac_start)     dcnt <= 3;
      else if (dcnt > 0) dcnt <= dcnt - 1;
   end
   assign dac_done = (dcnt == 1);

   typedef struct {
      bit         is_dac;
      logic [2:0] a;
      logic [7:0] d;
      int         gap;
      bit         gap_min;
      string      req;
   } item_t;

   item_t q[$];
   int checks = 0, errors = 0;
   longint cyc = 0, last_cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic push(bit dac, logic [2:0] a, logic [7:0] d, int g, bit gm, string r);
      item_t it;
      it.is_dac = dac; it.a = a; it.d = d; it.gap = g; it.gap_min = gm; it.req = r;
      q.push_back(it);
   endtask

   task automatic push_cold(logic [7:0] vc, logic [7:0] ph, logic [7:0] rs);
      push(0, 3'd6, 8'h1F, 0, 0, "R2");
      push(0, 3'd3, 8'h00, 0, 0, "R2");
      push(0, 3'd4, 8'h00, 0, 0, "R2");
      push(0, 3'd4, 8'h04, 0, 0, "R2");
      push(0, 3'd3, 8'h04, 3*N+2, 0, "R3");
      push(0, 3'd6, 8'h09, 0, 0, "R2");
      push(1, 3'd0, vc,    0, 0, "R4");
      push(0, 3'd3, 8'h14, 0, 0, "R2");
      push(0, 3'd4, 8'h06, 0, 0, "R2");
      push(0, 3'd6, 8'h01, 2*N+2, 0, "R3");
      push(0, 3'd3, 8'h1C, 0, 0, "R2");
      push(0, 3'd4, 8'h07, 0, 0, "R2");
      push(0, 3'd6, 8'h00, 0, 0, "R2");
      push(0, 3'd1, ph,    0, 0, "R5");
      push(0, 3'd7, 8'h00, 0, 0, "R2");
      push(0, 3'd0, rs,    N+2, 0, "R6");
   endtask

   task automatic push_down();
      push(0, 3'd4, 8'h06, 34*N, 1, "R8");
      push(0, 3'd6, 8'h08, 0, 0, "R8");
      push(0, 3'd3, 8'h14, 0, 0, "R8");
      push(1, 3'd0, 8'h00, 0, 0, "R8");
      push(0, 3'd4, 8'h04, 0, 0, "R8");
      push(0, 3'd3, 8'h04, 0, 0, "R8");
      push(0, 3'd6, 8'h1E, 0, 0, "R8");
      push(0, 3'd3, 8'h00, 0, 0, "R8");
      push(0, 3'd4, 8'h00, 0, 0, "R8");
   endtask

   // monitor: pops expected items as writes and DAC strobes appear
   always @(negedge clk) begin
      if (rst_n && (wr_valid || dac_start)) begin
         check(busy, "R11", "strobe while idle", int'(busy), 1);
         if (q.size() == 0) begin
            check(0, "R10", "unexpected event addr", int'(wr_addr), 0);
         end else begin
            item_t e;
            e = q.pop_front();
            if (e.is_dac) begin
               check(dac_start && !wr_valid, e.req, "dac strobe", int'(dac_start), 1);
               check(dac_value == e.d, e.req, "dac value", int'(dac_value), int'(e.d));
            end else begin
               check(wr_valid && wr_addr == e.a, e.req, "write addr",
                     int'({wr_valid, wr_addr}), int'({1'b1, e.a}));
               check(wr_data == e.d, e.req, "write data", int'(wr_data), int'(e.d));
            end
            if (e.gap != 0) begin
               if (e.gap_min)
                  check(int'(cyc - last_cyc) >= e.gap, "R3", "min gap",
                        int'(cyc - last_cyc), e.gap);
               else
                  check(int'(cyc - last_cyc) == e.gap, "R3", "gap",
                        int'(cyc - last_cyc), e.gap);
            end
         end
         last_cyc = cyc;
      end
   end

   task automatic pulse_on(bit vga);
      @(negedge clk); on_req = 1'b1; mode_vga = vga;
      @(negedge clk); on_req = 1'b0;
   endtask

   task automatic pulse_off();
      @(negedge clk); off_req = 1'b1;
      @(negedge clk); off_req = 1'b0;
   endtask

   task automatic wait_idle(string req);
      while (busy) @(negedge clk);
      repeat (5) @(negedge clk);
      check(q.size() == 0, req, "items left", q.size(), 0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(ready == 0, "R1", "ready", int'(ready), 0);
      check(busy == 0, "R1", "busy", int'(busy), 0);
      check(!wr_valid && !dac_start, "R1", "strobes", int'({wr_valid, dac_start}), 0);

      // R2/R4/R5/R6: cold QVGA, no stored common voltage -> 125
      phase_ok = 1'b1; phase_adj = 4'h5; vcom_ok = 1'b0;
      push_cold(8'd125, 8'h13, 8'h01);
      pulse_on(1'b0);
      check(busy == 1, "R11", "busy after request", int'(busy), 1);
      wait_idle("R2");
      check(ready == 1, "R6", "ready after power-on", int'(ready), 1);

      // R7/R5: warm VGA with stored phase 5 -> 0x0B
      push(0, 3'd1, 8'h0B, 0, 0, "R7");
      push(0, 3'd0, 8'h00, 0, 0, "R7");
      pulse_on(1'b1);
      wait_idle("R7");

      // R5: warm VGA without stored phase -> 0x01
      phase_ok = 1'b0;
      push(0, 3'd1, 8'h01, 0, 0, "R5");
      push(0, 3'd0, 8'h00, 0, 0, "R5");
      pulse_on(1'b1);
      wait_idle("R5");
      check(ready == 1, "R7", "ready kept", int'(ready), 1);

      // R8: power-down
      push_down();
      pulse_off();
      wait_idle("R8");
      check(ready == 0, "R8", "ready cleared", int'(ready), 0);

      // R9/R10/R4: cold VGA with stored voltage, on ignored and off held mid-sequence
      vcom_ok = 1'b1; vcom_val = 8'h40;
      push_cold(8'h40, 8'h01, 8'h00);
      push_down();
      pulse_on(1'b1);
      repeat (10) @(negedge clk);
      pulse_on(1'b0);
      pulse_off();
      wait_idle("R9");
      check(ready == 0, "R9", "ready after held off", int'(ready), 0);
      check(busy == 0, "R11", "busy at end", int'(busy), 0);

      finish_run();
   end
endmodule